// File: doc/BRIEF.md
# Overlap-Save Stream Framer and Tail Trimmer

This block wraps a block-based frequency-domain filter so that it can be used with continuous streams. On the input side it collects a stream of samples, each marked by a valid strobe, into overlapping frames of `FRAME_LEN` samples. Each new frame repeats the last `OVERLAP` samples of the frame before it and adds `FRAME_LEN-OVERLAP` fresh ones, which is one hop. Frames are handed out oldest sample first over a valid/ready port. New samples go into one region of a ring store while the previous frame is read from the rest of it, so filling and reading overlap in time.

On the return side, the block takes the `FRAME_LEN`-sample blocks that come back from the inverse transform. It drops the first `OVERLAP` samples of each block, because they are corrupted by circular wrap. It keeps the final hop's worth of samples in a FIFO, and the output stream pops one of them for each request strobe.

After reset, the history that comes before the first input sample is taken as zero. Half overlap (`OVERLAP = FRAME_LEN/2`) is the intended operating point. Two sticky flags report a dropped input sample and a premature output request.

Top module: `os_framer_trimmer`

## Requirements
- R1: While reset is held and just after it, `frm_valid`, `out_valid`, `ovf_flag` and `udf_flag` are 0.
- R2: Every frame is exactly `FRAME_LEN` accepted beats. `frm_last` is 1 on the final beat and 0 on all the others.
- R3: Samples of the history that come before the first input after reset read as zero. The first frame is therefore `OVERLAP` zeros followed by the first hop of inputs, oldest first.
- R4: The first `OVERLAP` samples of each frame equal the last `OVERLAP` samples of the previous frame. The remaining samples are the next hop of inputs, in arrival order.
- R5: While `frm_valid` is 1 and `frm_ready` is 0, `frm_data`, `frm_last` and `frm_valid` hold their values on the next cycle.
- R6: When a hop completes and the frame port is idle, `frm_valid` is 1 in the cycle after the completing input. If a frame is still being read, the new frame waits and starts in the cycle right after the last beat of the old frame is accepted. Any input that arrives while a frame is waiting is discarded, appears in no frame, and sets `ovf_flag`, which stays set until reset.
- R7: Returned samples are counted modulo `FRAME_LEN` from reset. Positions 0 to `OVERLAP-1` are discarded. Positions `OVERLAP` to `FRAME_LEN-1` are stored in order.
- R8: An `out_req` pulse made while stored data is present, after a complete block has arrived, gives `out_valid`=1 with the oldest stored sample on `out_data` in the next cycle. `out_valid` is 1 only in the cycle after a request.
- R9: An `out_req` made before the first complete returned block has arrived sets `udf_flag`, which stays set until reset. Such a request removes nothing and gives no `out_valid`.
- R10: An `out_req` made after the first complete block, with the FIFO empty, gives `out_valid`=0 and leaves `udf_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample |
| frm_valid | output | 1 | Frame beat valid |
| frm_data | output | DATA_W | Frame sample, oldest first |
| frm_last | output | 1 | Final beat of a frame |
| frm_ready | input | 1 | Consumer accepts the current frame beat |
| ret_valid | input | 1 | Returned block sample strobe |
| ret_data | input | DATA_W | Returned block sample |
| out_req | input | 1 | Request for one output sample |
| out_valid | output | 1 | Output sample valid, one cycle after a request |
| out_data | output | DATA_W | Output sample |
| ovf_flag | output | 1 | Sticky: an input was discarded while a frame waited |
| udf_flag | output | 1 | Sticky: output was requested before the first block arrived |

## Verification
A frame becomes visible one cycle after the input that completes a hop. A waiting frame follows with no gap after the old frame's last accepted beat. Because the frame data is combinational from stored state, a beat is checked in the same half-cycle in which the bench raises `frm_ready`. An output sample is due exactly one cycle after its request. The bench drives each request at a falling edge and checks `out_valid` and `out_data` at the next falling edge. The flags are read one cycle after the stimulus that should set them, or should leave them clear.

// File: rtl/osf_pkg.sv
package osf_pkg;

  // Advance a ring pointer by inc (inc < depth) with wrap.
  function automatic int ring_add(input int ptr, input int inc, input int depth);
    int s;
    s = ptr + inc;
    return (s >= depth) ? s - depth : s;
  endfunction

  // Leading zero samples left for the next frame after one hop.
  function automatic int pad_after(input int zpad, input int hop);
    return (zpad > hop) ? zpad - hop : 0;
  endfunction

  // A returned sample is kept when its position is past the wrap region.
  function automatic bit keep_pos(input int pos, input int overlap);
    return pos >= overlap;
  endfunction

endpackage

// File: rtl/osf_framer.sv
module osf_framer #(
  parameter int FRAME_LEN = 16,
  parameter int OVERLAP   = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              frm_valid,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_last,
  input  logic              frm_ready,
  output logic              seg_done,
  output logic              launch,
  output logic              ovf_flag
);
  localparam int HOP   = FRAME_LEN - OVERLAP;
  localparam int DEPTH = FRAME_LEN + HOP;
  localparam int PW    = $clog2(DEPTH);
  localparam int IW    = $clog2(FRAME_LEN);
  localparam int FW    = $clog2(HOP + 1);
  localparam int ZW    = $clog2(OVERLAP + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr, pend_start;
  logic [FW-1:0]     fill_cnt;
  logic [IW-1:0]     rd_idx;
  logic [ZW-1:0]     zpad, zleft;
  logic              busy, pend;

  logic              take, accept, done_frame, port_free;
  logic [PW-1:0]     seg_start, launch_start;

  assign take         = in_valid & ~pend;
  assign accept       = busy & frm_ready;
  assign done_frame   = accept & (rd_idx == IW'(FRAME_LEN - 1));
  assign port_free    = ~busy | done_frame;
  assign seg_done     = take & (fill_cnt == FW'(HOP - 1));
  assign launch       = (pend | seg_done) & port_free;
  assign seg_start    = PW'(osf_pkg::ring_add(int'(wr_ptr), HOP + 1, DEPTH));
  assign launch_start = pend ? pend_start : seg_start;

  assign frm_valid = busy;
  assign frm_last  = busy & (rd_idx == IW'(FRAME_LEN - 1));
  assign frm_data  = (int'(rd_idx) < int'(zleft)) ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      fill_cnt   <= '0;
      pend       <= 1'b0;
      pend_start <= '0;
      busy       <= 1'b0;
      rd_ptr     <= '0;
      rd_idx     <= '0;
      zpad       <= ZW'(OVERLAP);
      zleft      <= '0;
      ovf_flag   <= 1'b0;
    end else begin
      if (in_valid && pend) ovf_flag <= 1'b1;
      if (take) begin
        wr_ptr   <= PW'(osf_pkg::ring_add(int'(wr_ptr), 1, DEPTH));
        fill_cnt <= seg_done ? '0 : fill_cnt + 1'b1;
      end
      if (seg_done && !port_free) begin
        pend       <= 1'b1;
        pend_start <= seg_start;
      end else if (launch) begin
        pend <= 1'b0;
      end
      if (launch) begin
        busy   <= 1'b1;
        rd_ptr <= launch_start;
        rd_idx <= '0;
        zleft  <= zpad;
        zpad   <= ZW'(osf_pkg::pad_after(int'(zpad), HOP));
      end else if (done_frame) begin
        busy <= 1'b0;
      end else if (accept) begin
        rd_ptr <= PW'(osf_pkg::ring_add(int'(rd_ptr), 1, DEPTH));
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osf_trimmer.sv
module osf_trimmer #(
  parameter int FRAME_LEN = 16,
  parameter int OVERLAP   = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [DATA_W-1:0] ret_data,
  output logic              keep,
  output logic [DATA_W-1:0] keep_data,
  output logic              block_seen
);
  localparam int CW = $clog2(FRAME_LEN);

  logic [CW-1:0] pos;
  logic          blk_end;

  assign keep      = ret_valid & osf_pkg::keep_pos(int'(pos), OVERLAP);
  assign keep_data = ret_data;
  assign blk_end   = ret_valid & (pos == CW'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos        <= '0;
      block_seen <= 1'b0;
    end else if (ret_valid) begin
      pos <= blk_end ? '0 : pos + 1'b1;
      if (blk_end) block_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/osf_fifo.sv
module osf_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & ~full;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= AW'(osf_pkg::ring_add(int'(wp), 1, DEPTH));
      if (do_pop)  rp <= AW'(osf_pkg::ring_add(int'(rp), 1, DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/os_framer_trimmer.sv
module os_framer_trimmer #(
  parameter int FRAME_LEN = 16,
  parameter int OVERLAP   = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              frm_valid,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_last,
  input  logic              frm_ready,
  input  logic              ret_valid,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              out_req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              ovf_flag,
  output logic              udf_flag
);
  localparam int HOP = FRAME_LEN - OVERLAP;

  logic              fr_seg_done, fr_launch;
  logic              trm_keep, trm_seen;
  logic [DATA_W-1:0] trm_data, fifo_head;
  logic              fifo_empty, out_pop;

  osf_framer #(.FRAME_LEN(FRAME_LEN), .OVERLAP(OVERLAP), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last),
    .frm_ready(frm_ready), .seg_done(fr_seg_done), .launch(fr_launch),
    .ovf_flag(ovf_flag)
  );

  osf_trimmer #(.FRAME_LEN(FRAME_LEN), .OVERLAP(OVERLAP), .DATA_W(DATA_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_data(ret_data),
    .keep(trm_keep), .keep_data(trm_data), .block_seen(trm_seen)
  );

  osf_fifo #(.DEPTH(HOP), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(trm_keep), .din(trm_data),
    .pop(out_pop), .head(fifo_head), .empty(fifo_empty)
  );

  assign out_pop = out_req & trm_seen & ~fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      udf_flag  <= 1'b0;
    end else begin
      out_valid <= out_pop;
      if (out_pop) out_data <= fifo_head;
      if (out_req && !trm_seen) udf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/osf_checker.sv
module osf_checker #(
  parameter int FRAME_LEN = 16,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic              frm_last,
  input logic [DATA_W-1:0] frm_data,
  input logic              launch,
  input logic              out_req,
  input logic              out_valid,
  input logic              ovf_flag,
  input logic              udf_flag,
  input logic              block_seen
);
  localparam int BW = $clog2(FRAME_LEN + 1);
  logic [BW-1:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (frm_valid && frm_ready) beats <= frm_last ? '0 : beats + 1'b1;
  end

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |-> (frm_last == (beats == BW'(FRAME_LEN - 1))));

  assert_frame_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data) && $stable(frm_last)));

  assert_launch_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (!frm_valid || (frm_ready && frm_last)));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_out_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(out_req));

  assert_pop_after_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(block_seen));

  assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag |=> udf_flag);

  assert_no_udf_after_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udf_flag) |-> !$past(block_seen));
endmodule

bind os_framer_trimmer osf_checker #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
  .frm_last(frm_last), .frm_data(frm_data), .launch(fr_launch),
  .out_req(out_req), .out_valid(out_valid), .ovf_flag(ovf_flag),
  .udf_flag(udf_flag), .block_seen(trm_seen)
);

// File: tb/os_framer_trimmer_test.sv
`timescale 1ns/1ps
module os_framer_trimmer_test;
  localparam int L   = 16;
  localparam int K   = 8;
  localparam int HOP = L - K;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, frm_ready = 1'b0, ret_valid = 1'b0, out_req = 1'b0;
  logic [W-1:0] in_data = '0, ret_data = '0;
  logic frm_valid, frm_last, out_valid, ovf_flag, udf_flag;
  logic [W-1:0] frm_data, out_data;

  os_framer_trimmer #(.FRAME_LEN(L), .OVERLAP(K), .DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_last(frm_last),
    .frm_ready(frm_ready), .ret_valid(ret_valid), .ret_data(ret_data),
    .out_req(out_req), .out_valid(out_valid), .out_data(out_data),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 1'b0;
  int model [256];
  int n_in = 0;
  int seed_val = 11;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_frame(input int m, input int p);
    int a;
    a = m * HOP - K + p;
    return (a < 0) ? 0 : model[a];
  endfunction

  task automatic do_reset;
    rst_n = 1'b0; in_valid = 0; frm_ready = 0; ret_valid = 0; out_req = 0;
    n_in = 0;
    repeat (3) @(negedge clk);
    check(!frm_valid && !out_valid && !ovf_flag && !udf_flag, "R1 reset outputs",
          {frm_valid, out_valid, ovf_flag, udf_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!frm_valid && !out_valid && !ovf_flag && !udf_flag, "R1 after reset",
          {frm_valid, out_valid, ovf_flag, udf_flag}, 0);
  endtask

  // One hop of inputs; optionally expect an immediate frame launch (R6 timing).
  task automatic inject_hop(input bit expect_launch);
    for (int i = 0; i < HOP; i++) begin
      seed_val = (seed_val * 13 + 7) % 4093;
      in_valid = 1'b1; in_data = W'(seed_val);
      model[n_in] = seed_val; n_in++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (expect_launch) check(frm_valid == 1'b1, "R6 frame one cycle after hop", frm_valid, 1);
  endtask

  task automatic collect(input int m, input bit gappy, input string req);
    int p = 0;
    int guard = 0;
    while (!frm_valid && guard < 50) begin @(negedge clk); guard++; end
    guard = 0;
    while (p < L && guard < 200) begin
      frm_ready = gappy ? ((guard % 3) != 1) : 1'b1;
      if (frm_ready) begin
        check(frm_valid && (int'(frm_data) == exp_frame(m, p)), req, int'(frm_data), exp_frame(m, p));
        check(frm_last == (p == L - 1), "R2 last flag", frm_last, (p == L - 1));
        p++;
      end
      @(negedge clk);
      guard++;
    end
    frm_ready = 1'b0;
  endtask

  task automatic test_stream;
    do_reset();
    inject_hop(1'b1);
    collect(0, 1'b0, "R3 first frame zero history");
    inject_hop(1'b1);
    collect(1, 1'b1, "R4 overlap frame gappy ready");
    inject_hop(1'b1);
    collect(2, 1'b0, "R4 third frame");
  endtask

  task automatic test_stall;
    logic [W-1:0] held;
    do_reset();
    inject_hop(1'b1);
    collect(0, 1'b0, "R3 stall run frame 0");
    inject_hop(1'b1);
    held = frm_data;
    repeat (3) @(negedge clk);
    check(frm_valid && frm_data == held, "R5 hold while not ready", int'(frm_data), int'(held));
    inject_hop(1'b0);
    check(frm_valid && !frm_last, "R6 new frame waits", frm_last, 0);
    in_valid = 1'b1; in_data = W'(16'hBEEF);
    @(negedge clk);
    in_valid = 1'b0;
    check(ovf_flag == 1'b1, "R6 overflow on waiting input", ovf_flag, 1);
    collect(1, 1'b0, "R4 stalled frame 1");
    check(frm_valid == 1'b1, "R6 waiting frame starts at once", frm_valid, 1);
    collect(2, 1'b0, "R6 waiting frame content");
    inject_hop(1'b1);
    collect(3, 1'b0, "R6 dropped sample absent");
    check(ovf_flag == 1'b1, "R6 overflow sticky", ovf_flag, 1);
  endtask

  task automatic send_block(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      ret_valid = 1'b1; ret_data = W'(base + i);
      @(negedge clk);
    end
    ret_valid = 1'b0;
  endtask

  task automatic request(input bit expv, input int expd, input string req);
    out_req = 1'b1;
    @(negedge clk);
    out_req = 1'b0;
    check(out_valid == expv, req, out_valid, expv);
    if (expv) check(int'(out_data) == expd, req, int'(out_data), expd);
  endtask

  task automatic test_trim;
    do_reset();
    send_block(100, L);
    for (int i = 0; i < HOP; i++) request(1'b1, 100 + K + i, "R7 R8 kept tail in order");
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid only after request", out_valid, 0);
    request(1'b0, 0, "R10 empty fifo no data");
    check(udf_flag == 1'b0, "R10 no underflow when empty", udf_flag, 0);
    send_block(300, L);
    request(1'b1, 300 + K, "R7 second block tail");
  endtask

  task automatic test_underflow;
    do_reset();
    request(1'b0, 0, "R9 early request no data");
    check(udf_flag == 1'b1, "R9 underflow flag", udf_flag, 1);
    send_block(200, 12);
    request(1'b0, 0, "R9 partial block no pop");
    send_block(212, 4);
    request(1'b1, 200 + K, "R9 nothing removed early");
    check(udf_flag == 1'b1, "R9 underflow sticky", udf_flag, 1);
  endtask

  initial begin
    test_stream();
    test_stall();
    test_trim();
    test_underflow();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule